// File: doc/BRIEF.md
# Programmable Switching Activity Generator

This block is a deliberate power load. It is placed on a device to heat it in a controlled way during bench power and thermal characterisation. Each part of it exercises one kind of switching. A circulating shift chain has an activity set by the seed pattern loaded into it. A bank of flops inverts on every cycle. A cascade of XOR stages can run with or without registers between stages, so that glitches either ripple through the cascade or are stopped at each stage. A dual-port RAM is written and read on every cycle with pseudo-random data.

At run time, an operator picks a seed pattern and a pipeline mode to set how much of the logic switches. The operator then raises the run enable. With the enable low, every register holds its value, which gives an idle baseline. All of the activity is folded into a single heartbeat pin so that synthesis cannot remove any of the logic. The pin can also drive an LED.

Top module: `activity_gen`

## Requirements
- R1: While `rst_n` is low, the chain, the toggle bank, the XOR stage registers, the RAM read register, the RAM written-flags and the heartbeat counter clear to zero. The LFSR loads the nonzero value `LFSR_SEED`. After reset, `heartbeat` is 0.
- R2: When `pat_load` is high and `run_en` is low at a clock edge, the chain loads the pattern chosen by `pat_sel`. Code 0 sets bit 0 only. Code 1 sets every bit whose index is a multiple of 8. Code 2 sets every multiple of 4. Code 3 sets every even bit. `pat_load` has no effect while `run_en` is high.
- R3: On each enabled edge, the chain rotates by one place toward its most significant bit, and bit `CHAIN_LEN-1` wraps into bit 0.
- R4: On each enabled edge, every toggle-bank flop inverts.
- R5: The 32-bit LFSR advances on each enabled edge to `{s[30:0], s[31]^s[21]^s[1]^s[0]}` and is never zero.
- R6: Each XOR stage maps v to `v ^ (v << 1)` over `XOR_W` bits. The input to the first stage is the low `XOR_W` bits of the chain XOR the low `XOR_W` bits of the LFSR. With `pipe_mode` = 0, all `XOR_STAGES` stages are chained combinationally, and the cascade output reflects the current state.
- R7: With `pipe_mode` = 1, each stage after the first takes its input from the register of the previous stage, and the cascade output is the last stage register. Each stage register loads its stage result on every enabled edge, in either mode.
- R8: On each enabled edge, the RAM writes the LFSR low `RAM_DW` bits at address LFSR[`RAM_AW`-1:0]. On the same edge it registers the word at that address plus `RD_OFFSET` (mod depth), as stored before the edge, or zero if that location has not been written since reset.
- R9: The fold bit is the XOR reduction of the chain, the toggle bank, the cascade output and the RAM read register. On each enabled edge, the heartbeat counter adds the fold bit. `heartbeat` is the counter's MSB.
- R10: While `run_en` is low, and apart from the R2 load, no register changes, so `heartbeat` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Global activity enable |
| pat_sel | input | 2 | Seed pattern code for the chain |
| pat_load | input | 1 | Loads the chosen pattern while idle |
| pipe_mode | input | 1 | 1 = registered XOR cascade, 0 = combinational cascade |
| heartbeat | output | 1 | Divided fold of all activity |

## Verification
The checker assumes that `pat_load` carries meaning only during idle cycles. It also assumes that `pipe_mode` may change on any cycle, since the cascade output simply follows the mode select. The stimulus drives every input from a single task, one value per cycle, away from the clock edge. It raises `pat_load` both during idle cycles and during enabled cycles, so the idle-only rule is exercised. The bench sets the heartbeat divider to one bit, so every fold value shows up directly at the pin.

// File: rtl/act_pkg.sv
// Shared definitions for the switching activity generator.
// Assumes: LFSR width is fixed at 32 bits; pattern codes are 2 bits.
package act_pkg;

    localparam int LFSR_W = 32;

    typedef enum logic [1:0] {
        PAT_SINGLE = 2'd0,
        PAT_OCTET  = 2'd1,
        PAT_NIBBLE = 2'd2,
        PAT_ALT    = 2'd3
    } pat_e;

    // One shift of the maximal-length 32-bit LFSR (taps 32,22,2,1).
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/act_lfsr.sv
// Free-running pseudo-random source for the RAM traffic and the XOR input.
// Assumes: SEED is nonzero, so the sequence never locks at zero.
module act_lfsr
    import act_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] s_q;

    // Advance one step per enabled cycle; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  s_q <= SEED;
        else if (en) s_q <= lfsr_next(s_q);
    end

    assign state = s_q;

endmodule

// File: rtl/act_shift_chain.sv
// Circulating shift chain whose switching rate is set by the seed loaded
// into it. Assumes: the load is honoured only while the chain is idle.
module act_shift_chain
    import act_pkg::*;
#(
    parameter int LEN = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           load,
    input  logic [1:0]     sel,
    output logic [LEN-1:0] chain
);

    logic [LEN-1:0] seed_w;
    logic [LEN-1:0] chain_q;
    pat_e           sel_e;

    assign sel_e = pat_e'(sel);

    // Each seed bit is a constant per pattern, picked by the select.
    for (genvar i = 0; i < LEN; i++) begin : g_seed
        always_comb begin
            unique case (sel_e)
                PAT_SINGLE: seed_w[i] = (i == 0);
                PAT_OCTET:  seed_w[i] = (i % 8 == 0);
                PAT_NIBBLE: seed_w[i] = (i % 4 == 0);
                default:    seed_w[i] = (i % 2 == 0);
            endcase
        end
    end

    // Rotate toward the MSB when running; take the seed when idle and loading.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (en)       chain_q <= {chain_q[LEN-2:0], chain_q[LEN-1]};
        else if (load)     chain_q <= seed_w;
    end

    assign chain = chain_q;

endmodule

// File: rtl/act_xor_cascade.sv
// Cascade of XOR stages, each v ^ (v << 1). In combinational mode the
// stages feed each other directly so glitches ripple; in pipelined mode
// each stage reads the previous stage register. Assumes STAGES >= 1.
module act_xor_cascade #(
    parameter int W      = 32,
    parameter int STAGES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         pipe_mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_in [STAGES];
    logic [W-1:0] stg_w  [STAGES];
    logic [W-1:0] stg_q  [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign stg_in[k] = din;
        end else begin : g_rest
            assign stg_in[k] = pipe_mode ? stg_q[k-1] : stg_w[k-1];
        end
        assign stg_w[k] = stg_in[k] ^ (stg_in[k] << 1);
    end

    // Register every stage result on each enabled cycle.
    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            if (!rst_n)  stg_q[k] <= '0;
            else if (en) stg_q[k] <= stg_w[k];
        end
    end

    assign dout = pipe_mode ? stg_q[STAGES-1] : stg_w[STAGES-1];

endmodule

// File: rtl/act_dpram.sv
// Simple dual-port RAM exercised on every enabled cycle: one write port,
// one registered read port. Per-word written flags make unwritten reads
// return zero. Assumes the read and write addresses differ in a cycle.
module act_dpram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] wr_seen_q;
    logic [DW-1:0]    rd_q;

    // Storage array write, no reset so it maps to block memory.
    always_ff @(posedge clk) begin
        if (en) mem[waddr] <= wdata;
    end

    // Track which words have been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  wr_seen_q <= '0;
        else if (en) wr_seen_q[waddr] <= 1'b1;
    end

    // Registered read of the word held before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_q <= '0;
        else if (en) rd_q <= wr_seen_q[raddr] ? mem[raddr] : '0;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/activity_gen.sv
// Top of the switching activity generator. Ties the shift chain, toggle
// bank, XOR cascade and RAM together and folds all activity into a
// divided heartbeat. Assumes XOR_W <= CHAIN_LEN, XOR_W <= 32, RAM_DW <= 32.
module activity_gen
    import act_pkg::*;
#(
    parameter int                CHAIN_LEN  = 64,
    parameter int                TOG_W      = 32,
    parameter int                XOR_W      = 32,
    parameter int                XOR_STAGES = 4,
    parameter int                RAM_AW     = 6,
    parameter int                RAM_DW     = 32,
    parameter int                RD_OFFSET  = 17,
    parameter int                HB_DIV_W   = 8,
    parameter logic [LFSR_W-1:0] LFSR_SEED  = 32'h1D87_2B41
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic [1:0] pat_sel,
    input  logic       pat_load,
    input  logic       pipe_mode,
    output logic       heartbeat
);

    logic [LFSR_W-1:0]    lfsr_w;
    logic [CHAIN_LEN-1:0] chain_w;
    logic [TOG_W-1:0]     tog_q;
    logic [XOR_W-1:0]     xor_in_w;
    logic [XOR_W-1:0]     xor_out_w;
    logic [RAM_AW-1:0]    waddr_w;
    logic [RAM_AW-1:0]    raddr_w;
    logic [RAM_DW-1:0]    rdata_w;
    logic                 fold_w;
    logic [HB_DIV_W-1:0]  hb_q;

    act_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .state (lfsr_w)
    );

    act_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .load  (pat_load),
        .sel   (pat_sel),
        .chain (chain_w)
    );

    // Toggle bank: every flop inverts on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      tog_q <= '0;
        else if (run_en) tog_q <= ~tog_q;
    end

    assign xor_in_w = chain_w[XOR_W-1:0] ^ lfsr_w[XOR_W-1:0];

    act_xor_cascade #(.W(XOR_W), .STAGES(XOR_STAGES)) u_xor (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .pipe_mode (pipe_mode),
        .din       (xor_in_w),
        .dout      (xor_out_w)
    );

    assign waddr_w = lfsr_w[RAM_AW-1:0];
    assign raddr_w = waddr_w + RAM_AW'(RD_OFFSET);

    act_dpram #(.AW(RAM_AW), .DW(RAM_DW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .waddr (waddr_w),
        .wdata (lfsr_w[RAM_DW-1:0]),
        .raddr (raddr_w),
        .rdata (rdata_w)
    );

    assign fold_w = (^chain_w) ^ (^tog_q) ^ (^xor_out_w) ^ (^rdata_w);

    // Heartbeat divider: accumulate the fold bit on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      hb_q <= '0;
        else if (run_en) hb_q <= hb_q + HB_DIV_W'(fold_w);
    end

    assign heartbeat = hb_q[HB_DIV_W-1];

endmodule

// File: rtl/activity_gen_checks.sv
// Property checker for activity_gen, attached by bind below.
// Assumes pat_load only matters while run_en is low.
module activity_gen_checks #(
    parameter int CHAIN_LEN = 64,
    parameter int TOG_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_en,
    input logic                 pat_load,
    input logic                 heartbeat,
    input logic [CHAIN_LEN-1:0] chain,
    input logic [TOG_W-1:0]     tog,
    input logic [31:0]          lfsr
);

    a_r10_idle_heartbeat: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(heartbeat));

    a_r10_idle_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !pat_load) |=> $stable(chain));

    a_r10_idle_tog: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(tog));

    a_r4_tog_invert: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (tog == ~$past(tog)));

    a_r3_chain_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (chain == {$past(chain[CHAIN_LEN-2:0]), $past(chain[CHAIN_LEN-1])}));

    a_r3_ones_kept: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> ($countones(chain) == $countones($past(chain))));

    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && pat_load) |=> (chain != '0));

    a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 32'd0);

endmodule

bind activity_gen activity_gen_checks #(
    .CHAIN_LEN (CHAIN_LEN),
    .TOG_W     (TOG_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .pat_load  (pat_load),
    .heartbeat (heartbeat),
    .chain     (chain_w),
    .tog       (tog_q),
    .lfsr      (lfsr_w)
);

// File: tb/sim_activity_gen.sv
// Scoreboard bench: the driver models each edge from the requirements and
// queues the expected heartbeat; the monitor compares after the edge.
module sim_activity_gen;

    localparam int L   = 64;
    localparam int W   = 32;
    localparam int S   = 4;
    localparam int OFS = 17;
    localparam logic [31:0] SEED = 32'h1D87_2B41;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] pat_sel = 2'd0;
    logic       pat_load = 1'b0;
    logic       pipe_mode = 1'b0;
    logic       heartbeat;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    logic [L-1:0] m_chain;
    logic [31:0]  m_tog;
    logic [31:0]  m_lfsr;
    logic [W-1:0] m_r [S];
    logic [31:0]  m_mem [64];
    logic [63:0]  m_vld;
    logic [31:0]  m_rd;
    bit           m_hb;

    always #2 clk = ~clk;

    activity_gen #(
        .CHAIN_LEN(L), .TOG_W(32), .XOR_W(W), .XOR_STAGES(S),
        .RAM_AW(6), .RAM_DW(32), .RD_OFFSET(OFS), .HB_DIV_W(1), .LFSR_SEED(SEED)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pat_sel(pat_sel),
        .pat_load(pat_load), .pipe_mode(pipe_mode), .heartbeat(heartbeat)
    );

    function automatic logic [L-1:0] seed_of(input logic [1:0] sel);
        logic [L-1:0] p;
        for (int i = 0; i < L; i++) begin
            case (sel)
                2'd0:    p[i] = (i == 0);
                2'd1:    p[i] = (i % 8 == 0);
                2'd2:    p[i] = (i % 4 == 0);
                default: p[i] = (i % 2 == 0);
            endcase
        end
        return p;
    endfunction

    task automatic model_reset();
        m_chain = '0; m_tog = '0; m_lfsr = SEED; m_vld = '0; m_rd = '0; m_hb = 1'b0;
        for (int k = 0; k < S; k++) m_r[k] = '0;
    endtask

    // Expected effect of one clock edge, written from R2..R10.
    task automatic model_edge(input bit en, input logic [1:0] sel, input bit ld, input bit pm);
        logic [W-1:0] c [S];
        logic [W-1:0] sin;
        logic [W-1:0] xo;
        logic [5:0]   wa;
        logic [5:0]   ra;
        bit           fold;
        for (int k = 0; k < S; k++) begin
            if (k == 0) sin = m_chain[W-1:0] ^ m_lfsr[W-1:0];
            else        sin = pm ? m_r[k-1] : c[k-1];
            c[k] = sin ^ (sin << 1);
        end
        xo   = pm ? m_r[S-1] : c[S-1];
        fold = (^m_chain) ^ (^m_tog) ^ (^xo) ^ (^m_rd);
        if (en) begin
            wa = m_lfsr[5:0];
            ra = wa + 6'(OFS);
            m_rd = m_vld[ra] ? m_mem[ra] : 32'd0;
            m_mem[wa] = m_lfsr;
            m_vld[wa] = 1'b1;
            for (int k = 0; k < S; k++) m_r[k] = c[k];
            m_chain = {m_chain[L-2:0], m_chain[L-1]};
            m_tog = ~m_tog;
            m_hb = m_hb ^ fold;
            m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
        end else if (ld) begin
            m_chain = seed_of(sel);
        end
    endtask

    // Driver: drive one cycle of inputs, queue the expected heartbeat.
    task automatic step(input bit en, input logic [1:0] sel, input bit ld,
                        input bit pm, input string tag);
        @(negedge clk);
        run_en = en; pat_sel = sel; pat_load = ld; pipe_mode = pm;
        model_edge(en, sel, ld, pm);
        exp_q.push_back(m_hb);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each edge against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (heartbeat !== e) begin
                    n_bad++;
                    $display("FAIL %s heartbeat actual %0b expected %0b at %0t", t, heartbeat, e, $time);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_vec++;
        if (heartbeat !== 1'b0) begin   // R1 reset state
            n_bad++;
            $display("FAIL R1 heartbeat actual %0b expected 0", heartbeat);
        end
        // R2: idle load of the densest pattern, then R6 combinational run.
        step(1'b0, 2'd3, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 24; i++) step(1'b1, 2'd0, 1'b0, 1'b0, "R6");
        // R2: load requests while running must be ignored.
        for (int i = 0; i < 12; i++) step(1'b1, 2'(i % 4), 1'b1, 1'b0, "R2");
        // R7: registered cascade.
        for (int i = 0; i < 40; i++) step(1'b1, 2'd0, 1'b0, 1'b1, "R7");
        // R10: idle, nothing moves.
        for (int i = 0; i < 12; i++) step(1'b0, 2'd1, 1'b0, 1'b1, "R10");
        // R2/R3/R4: every pattern, alternating cascade modes.
        for (int p = 0; p < 4; p++) begin
            step(1'b0, 2'(p), 1'b1, 1'b0, "R2");
            for (int i = 0; i < 30; i++) step(1'b1, 2'd0, 1'b0, 1'(p % 2), "R3");
        end
        // R7: mode flips every cycle.
        for (int i = 0; i < 30; i++) step(1'b1, 2'd0, 1'b0, 1'(i % 2), "R7");
        // R8/R5/R9: long run wraps the RAM many times.
        for (int i = 0; i < 400; i++) step(1'b1, 2'd0, 1'b0, 1'(i / 100 % 2), "R8");
        // R4/R10: bursty enable.
        for (int i = 0; i < 60; i++) step(1'(i % 3 != 0), 2'd2, 1'(i % 5 == 0), 1'b0, "R4");
        // R9: single-one pattern, lowest activity.
        step(1'b0, 2'd0, 1'b1, 1'b1, "R9");
        for (int i = 0; i < 50; i++) step(1'b1, 2'd0, 1'b0, 1'b1, "R9");
        // R1: reset again mid-run, heartbeat returns to zero.
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0; pat_load = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        n_vec++;
        if (heartbeat !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 heartbeat actual %0b expected 0 after second reset", heartbeat);
        end
        step(1'b0, 2'd3, 1'b1, 1'b0, "R5");
        for (int i = 0; i < 40; i++) step(1'b1, 2'd0, 1'b0, 1'b0, "R5");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule